// File: doc/BRIEF.md
# Tick-Count Alarm Timer

The block keeps a free-running 48-bit count of 32768 Hz ticks. Because each second is 2^15 ticks, bits 14..0 of the count are the fraction of a second and bits 47..15 are whole seconds. Software sees the count as three 16-bit words on a plain 16-bit register bus. It can preset the time one word at a time and read the time back.

A 48-bit compare value uses the same three-word, sub-second layout. On every tick the block tests the count against the compare value. On a match it latches a sticky alarm status bit, which software clears by writing a one to it. The alarm interrupt line is that status bit gated by an enable bit.

The register bus has two windows, chosen by `bus_win`: the time window holds the count and the compare words, and the interrupt window holds the status and enable words. The bus never stalls and has no back-pressure. Every request is taken in the cycle it is presented, and read data returns on the next clock edge.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset the count, the compare value, the alarm status, the alarm enable, `bus_rdata` and `alarm_irq` are all zero.
- R2: Each clock cycle with `tick_en` high and no count write advances the count by one. The all-ones value wraps to zero.
- R3: In the time window the count is read and written as low, middle and high words at byte offsets 0x00, 0x02 and 0x04. Carries ripple across word boundaries. Whole seconds S map to low = (S<<15) & 0x8000, middle = S>>1 and high = S>>17.
- R4: A write to one count word loads only that word on the next edge and leaves the other words unchanged. A tick in the same cycle as a count write is dropped, and counting resumes from the loaded value on the next tick.
- R5: In the time window the compare value is read and written as low, middle and high words at byte offsets 0x08, 0x0A and 0x0C. It changes only when written.
- R6: A read request (`bus_req` high, `bus_we` low) loads `bus_rdata` on the next edge with the addressed word as it stood before that edge. Unmapped offsets read as zero. `bus_rdata` holds its value in cycles with no read request.
- R7: Without a tick or a count write the count holds its value, so two successive reads of the three words give equal results.
- R8: In a cycle where `tick_en` is high and the count equals the compare value, the alarm status (bit 0 of the interrupt window at offset 0x1E) is set at the next edge. A single match sets it only once.
- R9: Writing 1 to bit 0 at interrupt-window offset 0x1E clears the alarm status, and writing 0 there has no effect. The status otherwise stays set, and a new match in the same cycle wins over a clear.
- R10: The alarm enable is bit 0 at interrupt-window offset 0x1C, readable and writable. `alarm_irq` is high exactly when both the status and the enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32768 Hz tick |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = time window, 1 = interrupt window |
| bus_addr | input | 5 | Byte offset of a 16-bit word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
Register writes, tick increments and the alarm status all take effect one clock edge after the cycle that carries the stimulus. Read data appears one edge after the request, and `alarm_irq` follows the status and enable registers in that same cycle. The bench drives its inputs 1 ns after a rising edge. A behavioural model updates on each rising edge, and `bus_rdata` and `alarm_irq` are compared against it at every falling edge. Directed reads, taken after the read edge, also check the word layout, the carries, the dropped tick, the once-per-match rule and the clear-on-one behaviour against values worked out from the requirements.

// File: rtl/tat_pkg.sv
package tat_pkg;
  // word indices (byte offset >> 1) inside each window
  localparam int CNT_IDX = 0;
  localparam int CMP_IDX = 4;
  localparam int ENA_IDX = 14;
  localparam int STS_IDX = 15;

  typedef enum logic {
    WIN_TIME = 1'b0,
    WIN_IRQ  = 1'b1
  } win_e;
endpackage

// File: rtl/tat_counter.sv
module tat_counter #(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int NW     = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [NW-1:0]     wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (|wr_en) begin
      // word load wins over the tick in the same cycle
      for (int i = 0; i < NW; i++) begin
        if (wr_en[i]) cnt[i*WORD_W +: WORD_W] <= wr_data;
      end
    end else if (tick_en) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tat_compare.sv
module tat_compare #(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int NW     = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [NW-1:0]     wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cmp,
  output logic              match_tick
);

  logic [NW-1:0] word_eq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (wr_en[i]) cmp[i*WORD_W +: WORD_W] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_eq
    assign word_eq[g] = (cnt[g*WORD_W +: WORD_W] == cmp[g*WORD_W +: WORD_W]);
  end

  // sampled once per tick only
  assign match_tick = tick_en & (&word_eq);

endmodule

// File: rtl/tat_regs.sv
module tat_regs
  import tat_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5,
  parameter int NW     = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wbit0,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp,
  input  logic              match_tick,
  output logic [NW-1:0]     cnt_wr,
  output logic [NW-1:0]     cmp_wr,
  output logic [WORD_W-1:0] rdata,
  output logic              alarm_sts,
  output logic              alarm_ena
);

  logic [ADDR_W-2:0] idx;
  logic              unused_lsb;
  logic              wr_time;
  logic              wr_irq;
  logic              sts_clr;
  logic [WORD_W-1:0] rd_val;

  assign idx        = bus_addr[ADDR_W-1:1];
  assign unused_lsb = bus_addr[0];
  assign wr_time    = bus_req && bus_we && (bus_win == WIN_TIME);
  assign wr_irq     = bus_req && bus_we && (bus_win == WIN_IRQ);
  assign sts_clr    = wr_irq && (int'(idx) == STS_IDX) && wbit0;

  for (genvar g = 0; g < NW; g++) begin : g_dec
    assign cnt_wr[g] = wr_time && (int'(idx) == CNT_IDX + g);
    assign cmp_wr[g] = wr_time && (int'(idx) == CMP_IDX + g);
  end

  always_comb begin
    rd_val = '0;
    if (bus_win == WIN_TIME) begin
      for (int i = 0; i < NW; i++) begin
        if (int'(idx) == CNT_IDX + i) rd_val = cnt[i*WORD_W +: WORD_W];
        if (int'(idx) == CMP_IDX + i) rd_val = cmp[i*WORD_W +: WORD_W];
      end
    end else begin
      if (int'(idx) == STS_IDX) rd_val = {{(WORD_W-1){1'b0}}, alarm_sts};
      if (int'(idx) == ENA_IDX) rd_val = {{(WORD_W-1){1'b0}}, alarm_ena};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata     <= '0;
      alarm_sts <= 1'b0;
      alarm_ena <= 1'b0;
    end else begin
      if (bus_req && !bus_we) rdata <= rd_val;
      if (match_tick)   alarm_sts <= 1'b1;
      else if (sts_clr) alarm_sts <= 1'b0;
      if (wr_irq && (int'(idx) == ENA_IDX)) alarm_ena <= wbit0;
    end
  end

endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer #(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              alarm_irq
);

  localparam int NW = CNT_W / WORD_W;

  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] cmp_val;
  logic [NW-1:0]    cnt_wr;
  logic [NW-1:0]    cmp_wr;
  logic             match_tick;
  logic             alarm_sts;
  logic             alarm_ena;

  tat_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W), .NW(NW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (cnt_wr),
    .wr_data (bus_wdata),
    .cnt     (cnt_val)
  );

  tat_compare #(.CNT_W(CNT_W), .WORD_W(WORD_W), .NW(NW)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .wr_en      (cmp_wr),
    .wr_data    (bus_wdata),
    .cnt        (cnt_val),
    .cmp        (cmp_val),
    .match_tick (match_tick)
  );

  tat_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NW(NW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_win    (bus_win),
    .bus_addr   (bus_addr),
    .wbit0      (bus_wdata[0]),
    .cnt        (cnt_val),
    .cmp        (cmp_val),
    .match_tick (match_tick),
    .cnt_wr     (cnt_wr),
    .cmp_wr     (cmp_wr),
    .rdata      (bus_rdata),
    .alarm_sts  (alarm_sts),
    .alarm_ena  (alarm_ena)
  );

  assign alarm_irq = alarm_sts & alarm_ena;

endmodule

// File: rtl/tick_alarm_timer_chk.sv
module tick_alarm_timer_chk
  import tat_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_win,
  input logic [ADDR_W-2:0] idx,
  input logic              wbit0,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [CNT_W-1:0]  cmp_val,
  input logic              alarm_sts,
  input logic              alarm_irq
);

  localparam int NW = CNT_W / WORD_W;

  logic any_wr;
  logic cnt_wr;
  logic cmp_wr;
  logic sts_clr;
  logic ena_off;

  assign any_wr  = bus_req && bus_we;
  assign cnt_wr  = any_wr && !bus_win && (int'(idx) < CNT_IDX + NW);
  assign cmp_wr  = any_wr && !bus_win && (int'(idx) >= CMP_IDX) && (int'(idx) < CMP_IDX + NW);
  assign sts_clr = any_wr && bus_win && (int'(idx) == STS_IDX) && wbit0;
  assign ena_off = any_wr && bus_win && (int'(idx) == ENA_IDX) && !wbit0;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt_val));

  p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_wr |=> $stable(cmp_val));

  p_alarm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (cnt_val == cmp_val)) |=> alarm_sts);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_sts && !sts_clr) |=> alarm_sts);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ena_off |=> !alarm_irq);

endmodule

bind tick_alarm_timer tick_alarm_timer_chk #(
  .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_win   (bus_win),
  .idx       (bus_addr[ADDR_W-1:1]),
  .wbit0     (bus_wdata[0]),
  .cnt_val   (cnt_val),
  .cmp_val   (cmp_val),
  .alarm_sts (alarm_sts),
  .alarm_irq (alarm_irq)
);

// File: tb/test_tick_alarm_timer.sv
module test_tick_alarm_timer;

  localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_win = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        alarm_irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  longint unsigned m_cnt = 0;
  longint unsigned m_cmp = 0;
  bit              m_sts = 1'b0;
  bit              m_ena = 1'b0;
  logic [15:0]     m_rd  = '0;

  always #5 clk = ~clk;

  tick_alarm_timer i_tick_alarm_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_win   (bus_win),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alarm_irq (alarm_irq)
  );

  function automatic logic [15:0] model_read(bit win, int idx);
    if (!win) begin
      if (idx < 3) return 16'(m_cnt >> (16*idx));
      if (idx >= 4 && idx < 7) return 16'(m_cmp >> (16*(idx-4)));
      return 16'h0;
    end
    if (idx == 15) return {15'h0, m_sts};
    if (idx == 14) return {15'h0, m_ena};
    return 16'h0;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_sts = 1'b0; m_ena = 1'b0; m_rd = '0;
    end else begin
      int  idx;
      bit  hit;
      bit  wr;
      idx = int'(bus_addr) >> 1;
      wr  = bus_req && bus_we;
      hit = tick_en && (m_cnt == m_cmp);
      if (bus_req && !bus_we) m_rd = model_read(bus_win, idx);
      if (wr && !bus_win && idx < 3)
        m_cnt = (m_cnt & ~(64'hFFFF << (16*idx))) | (longint'(bus_wdata) << (16*idx));
      else if (tick_en)
        m_cnt = (m_cnt + 1) & MASK;
      if (wr && !bus_win && idx >= 4 && idx < 7)
        m_cmp = (m_cmp & ~(64'hFFFF << (16*(idx-4)))) | (longint'(bus_wdata) << (16*(idx-4)));
      if (hit) m_sts = 1'b1;
      else if (wr && bus_win && idx == 15 && bus_wdata[0]) m_sts = 1'b0;
      if (wr && bus_win && idx == 14) m_ena = bus_wdata[0];
    end
  end

  // cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL R6 cycle rdata actual=%h expected=%h", bus_rdata, m_rd);
      end
      vectors++;
      if (alarm_irq !== (m_sts & m_ena)) begin
        errors++;
        $display("FAIL R10 cycle irq actual=%b expected=%b", alarm_irq, m_sts & m_ena);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit win, logic [4:0] addr, logic [15:0] data, bit tk = 1'b0);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_win = win; bus_addr = addr; bus_wdata = data;
    tick_en = tk;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(bit win, logic [4:0] addr, output logic [15:0] v);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b0; bus_win = win; bus_addr = addr;
    @(posedge clk); #1;
    bus_req = 1'b0;
    v = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tick_en = 1'b1;
    @(posedge clk); #1;
    tick_en = 1'b0;
  endtask

  task automatic set_cnt(logic [15:0] lo, logic [15:0] mi, logic [15:0] hi);
    wr(1'b0, 5'h00, lo);
    wr(1'b0, 5'h02, mi);
    wr(1'b0, 5'h04, hi);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2, lo, mi, hi;
    longint unsigned secs;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, 5'h00, v); chk("R1 cnt lo", v, 16'h0);
    rd(1'b0, 5'h04, v); chk("R1 cnt hi", v, 16'h0);
    rd(1'b0, 5'h08, v); chk("R1 cmp lo", v, 16'h0);
    rd(1'b1, 5'h1E, v); chk("R1 status", v, 16'h0);
    rd(1'b1, 5'h1C, v); chk("R1 enable", v, 16'h0);
    chk("R1 irq", {15'h0, alarm_irq}, 16'h0);

    // R2 plain ticking
    repeat (3) tick();
    rd(1'b0, 5'h00, v); chk("R2 three ticks", v, 16'h3);

    // R3 carry across all word boundaries
    set_cnt(16'hFFFF, 16'hFFFF, 16'h0001);
    tick();
    rd(1'b0, 5'h00, v); chk("R3 carry lo", v, 16'h0000);
    rd(1'b0, 5'h02, v); chk("R3 carry mid", v, 16'h0000);
    rd(1'b0, 5'h04, v); chk("R3 carry hi", v, 16'h0002);

    // R3 seconds layout: S = 0x12345, fraction all ones, then one tick
    set_cnt(16'hFFFF, 16'h91A2, 16'h0000);
    tick();
    rd(1'b0, 5'h00, lo); rd(1'b0, 5'h02, mi); rd(1'b0, 5'h04, hi);
    secs = (longint'(hi) << 17) | (longint'(mi) << 1) | (longint'(lo) >> 15);
    chk("R3 seconds roll", 16'(secs), 16'h2346);
    chk("R3 fraction zero", lo & 16'h7FFF, 16'h0000);

    // R4 single-word load, tick dropped on a write cycle
    set_cnt(16'h1234, 16'h5678, 16'h9ABC);
    wr(1'b0, 5'h02, 16'hAAAA);
    rd(1'b0, 5'h00, v); chk("R4 lo kept", v, 16'h1234);
    rd(1'b0, 5'h02, v); chk("R4 mid loaded", v, 16'hAAAA);
    rd(1'b0, 5'h04, v); chk("R4 hi kept", v, 16'h9ABC);
    wr(1'b0, 5'h00, 16'h0010, 1'b1);
    rd(1'b0, 5'h00, v); chk("R4 tick dropped", v, 16'h0010);
    tick();
    rd(1'b0, 5'h00, v); chk("R4 resumes", v, 16'h0011);

    // R5 compare words
    wr(1'b0, 5'h08, 16'h1111); wr(1'b0, 5'h0A, 16'h2222); wr(1'b0, 5'h0C, 16'h3333);
    rd(1'b0, 5'h08, v); chk("R5 cmp lo", v, 16'h1111);
    rd(1'b0, 5'h0A, v); chk("R5 cmp mid", v, 16'h2222);
    rd(1'b0, 5'h0C, v); chk("R5 cmp hi", v, 16'h3333);

    // R6 unmapped offsets
    rd(1'b0, 5'h06, v); chk("R6 hole 0x06", v, 16'h0);
    rd(1'b0, 5'h0E, v); chk("R6 hole 0x0E", v, 16'h0);
    rd(1'b1, 5'h00, v); chk("R6 irq window 0x00", v, 16'h0);

    // R7 stable between ticks
    rd(1'b0, 5'h00, v); rd(1'b0, 5'h00, v2);
    chk("R7 reread equal", v2, v);
    tick();
    rd(1'b0, 5'h00, v2); chk("R7 after tick", v2, v + 16'h1);

    // R8 match sets status once
    wr(1'b1, 5'h1E, 16'h0001);
    rd(1'b1, 5'h1E, v); chk("R9 cleared", v, 16'h0);
    set_cnt(16'h0005, 16'h0000, 16'h0000);
    wr(1'b0, 5'h08, 16'h0006); wr(1'b0, 5'h0A, 16'h0000); wr(1'b0, 5'h0C, 16'h0000);
    tick();
    rd(1'b1, 5'h1E, v); chk("R8 no match yet", v, 16'h0);
    tick();
    rd(1'b1, 5'h1E, v); chk("R8 match sets", v, 16'h1);
    wr(1'b1, 5'h1E, 16'h0000);
    rd(1'b1, 5'h1E, v); chk("R9 write zero ignored", v, 16'h1);
    wr(1'b1, 5'h1E, 16'h0001);
    rd(1'b1, 5'h1E, v); chk("R9 write one clears", v, 16'h0);
    tick();
    rd(1'b1, 5'h1E, v); chk("R8 once per match", v, 16'h0);

    // R10 enable gating
    wr(1'b1, 5'h1C, 16'h0001);
    rd(1'b1, 5'h1C, v); chk("R10 enable reads", v, 16'h1);
    chk("R10 irq low no status", {15'h0, alarm_irq}, 16'h0);
    set_cnt(16'h0006, 16'h0000, 16'h0000);
    tick();
    chk("R10 irq high", {15'h0, alarm_irq}, 16'h1);
    wr(1'b1, 5'h1C, 16'h0000);
    chk("R10 irq masked", {15'h0, alarm_irq}, 16'h0);
    rd(1'b1, 5'h1E, v); chk("R10 status kept", v, 16'h1);

    // R2 wrap at full width
    set_cnt(16'hFFFF, 16'hFFFF, 16'hFFFF);
    tick();
    rd(1'b0, 5'h00, v); chk("R2 wrap lo", v, 16'h0);
    rd(1'b0, 5'h04, v); chk("R2 wrap hi", v, 16'h0);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule